// File: doc/BRIEF.md
# Configurable Logic Cell with Serial Configuration Chain

This block models a single programmable cell of a logic fabric. A 16-row truth table is indexed by four select inputs and produces a combinational result. An output register can capture that result; it has a clock enable and a synchronous set/reset. A final multiplexer chooses whether the cell drives the combinational result or the registered one. The same 16 storage bits can also serve as a 16x1 writable memory with asynchronous read, or as a 16-stage shift register whose output tap is chosen by the select inputs.

All configuration is volatile and is loaded serially. While the configuration enable is high, each rising clock edge moves one bit in at the serial input. The bit that falls off the far end appears at the serial output, so cells can be chained into one long configuration path. The configuration word holds the truth table, a two-bit memory mode, the output-select bit and the value that the set/reset forces.

Top module: `cfg_logic_cell`

## Requirements
- R1: A synchronous active-high `rst` clears every configuration bit and the output register, so `cell_out` and `cfg_dout` are 0 after reset.
- R2: While `cfg_en` is high, each rising edge shifts `cfg_din` into a 20-bit chain. `cfg_dout` always shows the oldest bit of that chain, which is the bit shifted in 20 enabled edges earlier.
- R3: The serial word is sent MSB first in this order: truth-table rows 15 down to 0, then mode[1:0], then the output-select bit, then the set/reset value bit.
- R4: In logic mode (mode 00), the combinational result is the truth-table row whose index is `lut_sel`, with `lut_sel[3]` as the most significant index bit.
- R5: In memory mode (mode 01), `mem_we` high at a rising edge stores `mem_din` into the row addressed by `lut_sel`. The row read at `lut_sel` is visible without a clock.
- R6: In shift mode (mode 10), `mem_we` high at a rising edge shifts `mem_din` into row 0 and moves each row up by one. The result is row `lut_sel`, which is a tap of `lut_sel`+1 stages.
- R7: The output register loads the combinational result on a rising edge when `ce` is high, and holds its value when `ce` is low.
- R8: `sr` high at a rising edge forces the output register to the set/reset value bit (0 clears, 1 sets). `sr` takes priority over `ce`.
- R9: With the output-select bit at 1, `cell_out` is the output register. With it at 0, `cell_out` is the combinational result.
- R10: While `cfg_en` is high, `mem_we`, `ce` and `sr` have no effect: the table is changed only by the configuration shift, and the output register holds.
- R11: In logic mode and in the reserved mode 11, `mem_we` leaves the truth table unchanged. Mode 11 reads like logic mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output to the next cell |
| lut_sel | input | 4 | Table index, memory address and shift tap |
| ce | input | 1 | Output register clock enable |
| sr | input | 1 | Synchronous set/reset of the output register |
| mem_we | input | 1 | Write enable (memory mode) or shift enable (shift mode) |
| mem_din | input | 1 | Data for memory writes and shifts |
| cell_out | output | 1 | Cell output after the output-select multiplexer |

## Verification
The hardest state to reach is a configuration load that cuts across user activity. In that case `ce`, `sr` and `mem_we` are all high while the word is still part shifted, and the fields that decide what `cell_out` shows change on every edge. The stimulus drives every configuration load with those controls asserted. The random phase also raises `cfg_en` for isolated cycles in the middle of memory and shift traffic. Deep shift taps are reached by pushing a full 16-bit pattern through shift mode and then sweeping every tap.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int LUT_K    = 4;
    localparam int LUT_ROWS = 1 << LUT_K;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_RAM   = 2'b01,
        MODE_SHIFT = 2'b10,
        MODE_RSVD  = 2'b11
    } lut_mode_e;

    // Packed MSB first, matching the serial order of the chain.
    typedef struct packed {
        logic [LUT_ROWS-1:0] truth;
        lut_mode_e           mode;
        logic                reg_out;
        logic                sr_val;
    } cell_cfg_t;

    localparam int CFG_BITS = $bits(cell_cfg_t);

    function automatic logic is_ram(input lut_mode_e m);
        return m == MODE_RAM;
    endfunction

    function automatic logic is_shift(input lut_mode_e m);
        return m == MODE_SHIFT;
    endfunction

endpackage

// File: rtl/lcell_cfg_store.sv
module lcell_cfg_store
    import lcell_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_din,
    output logic                cfg_dout,
    input  logic [LUT_K-1:0]    addr,
    input  logic                mem_we,
    input  logic                mem_din,
    output logic [LUT_ROWS-1:0] truth_q,
    output logic                reg_out_q,
    output logic                sr_val_q
);

    cell_cfg_t           cfg_r;
    cell_cfg_t           cfg_nxt;
    logic [LUT_ROWS-1:0] row_nxt;
    logic                ram_go;
    logic                shift_go;

    assign ram_go   = !cfg_en && mem_we && is_ram(cfg_r.mode);
    assign shift_go = !cfg_en && mem_we && is_shift(cfg_r.mode);

    for (genvar i = 0; i < LUT_ROWS; i++) begin : g_row
        if (i == 0) begin : g_first
            assign row_nxt[i] = (ram_go && addr == LUT_K'(i)) ? mem_din :
                                shift_go ? mem_din : cfg_r.truth[i];
        end else begin : g_rest
            assign row_nxt[i] = (ram_go && addr == LUT_K'(i)) ? mem_din :
                                shift_go ? cfg_r.truth[i-1] : cfg_r.truth[i];
        end
    end

    always_comb begin
        if (cfg_en) begin
            cfg_nxt = cell_cfg_t'({cfg_r[CFG_BITS-2:0], cfg_din});
        end else begin
            cfg_nxt       = cfg_r;
            cfg_nxt.truth = row_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_r <= '0;
        else     cfg_r <= cfg_nxt;
    end

    assign cfg_dout  = cfg_r[CFG_BITS-1];
    assign truth_q   = cfg_r.truth;
    assign reg_out_q = cfg_r.reg_out;
    assign sr_val_q  = cfg_r.sr_val;

    // R2: the chain advances by exactly one place per enabled edge
    assert_chain_shift_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_dout == $past(cfg_r[CFG_BITS-2]));

    // R5: a memory-mode write lands at the addressed row
    assert_ram_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && mem_we && cfg_r.mode == MODE_RAM)
        |=> truth_q[$past(addr)] == $past(mem_din));

    // R6: a shift places the new bit in row 0
    assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && mem_we && cfg_r.mode == MODE_SHIFT) |=> truth_q[0] == $past(mem_din));

    // R11: logic and reserved modes never alter the table outside configuration
    assert_table_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && (cfg_r.mode == MODE_LOGIC || cfg_r.mode == MODE_RSVD))
        |=> $stable(truth_q));

endmodule

// File: rtl/lcell_lut_read.sv
module lcell_lut_read
    import lcell_pkg::*;
#(
    parameter int K = LUT_K,
    localparam int ROWS = 1 << K
) (
    input  logic [ROWS-1:0] truth,
    input  logic [K-1:0]    addr,
    output logic            rd
);

    assign rd = truth[addr];

endmodule

// File: rtl/lcell_out_stage.sv
module lcell_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic cfg_en,
    input  logic ce,
    input  logic sr,
    input  logic sr_val,
    input  logic reg_out,
    input  logic lut_rd,
    output logic cell_out
);

    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)         q_r <= 1'b0;
        else if (cfg_en) q_r <= q_r;
        else if (sr)     q_r <= sr_val;
        else if (ce)     q_r <= lut_rd;
    end

    assign cell_out = reg_out ? q_r : lut_rd;

    // R7: an enabled edge captures the combinational result
    assert_ff_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !sr && ce) |=> q_r == $past(lut_rd));

    // R7: with the enable low the register holds
    assert_ff_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !sr && !ce) |=> $stable(q_r));

    // R8: set/reset wins over the enable
    assert_sr_priority_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && sr) |=> q_r == $past(sr_val));

    // R10: configuration freezes the register
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable(q_r));

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import lcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic             cfg_dout,
    input  logic [LUT_K-1:0] lut_sel,
    input  logic             ce,
    input  logic             sr,
    input  logic             mem_we,
    input  logic             mem_din,
    output logic             cell_out
);

    logic [LUT_ROWS-1:0] truth;
    logic                reg_out;
    logic                sr_val;
    logic                lut_rd;

    lcell_cfg_store u_store (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .cfg_din   (cfg_din),
        .cfg_dout  (cfg_dout),
        .addr      (lut_sel),
        .mem_we    (mem_we),
        .mem_din   (mem_din),
        .truth_q   (truth),
        .reg_out_q (reg_out),
        .sr_val_q  (sr_val)
    );

    lcell_lut_read #(.K(LUT_K)) u_read (
        .truth (truth),
        .addr  (lut_sel),
        .rd    (lut_rd)
    );

    lcell_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .ce       (ce),
        .sr       (sr),
        .sr_val   (sr_val),
        .reg_out  (reg_out),
        .lut_rd   (lut_rd),
        .cell_out (cell_out)
    );

    // R1: reset leaves both outputs low
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cell_out == 1'b0 || !reg_out) && cfg_dout == 1'b0);

endmodule

// File: tb/tb_cfg_logic_cell.sv
`timescale 1ns/1ps
module tb_cfg_logic_cell;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_dout;
    logic [3:0] lut_sel = 4'd0;
    logic       ce = 1'b0;
    logic       sr = 1'b0;
    logic       mem_we = 1'b0;
    logic       mem_din = 1'b0;
    logic       cell_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Bench model of the requirements: serial word per R3 and the output register
    logic [19:0] mword = '0;
    logic        mq = 1'b0;

    always #2.5 clk = ~clk;

    cfg_logic_cell dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
        .lut_sel(lut_sel), .ce(ce), .sr(sr), .mem_we(mem_we), .mem_din(mem_din),
        .cell_out(cell_out)
    );

    task automatic check(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_out(input logic [3:0] s);
        return mword[1] ? mq : mword[4 + s];
    endfunction

    function automatic string mode_tag();
        if (mword[1]) return "R9";
        case (mword[3:2])
            2'b01:   return "R5";
            2'b10:   return "R6";
            2'b11:   return "R11";
            default: return "R4";
        endcase
    endfunction

    task automatic cyc(input logic en, input logic din, input logic [3:0] s,
                       input logic c, input logic r, input logic w, input logic d,
                       input string tag);
        logic rd;
        @(negedge clk);
        cfg_en = en; cfg_din = din; lut_sel = s; ce = c; sr = r; mem_we = w; mem_din = d;
        #1;
        check(cell_out, exp_out(s), (tag != "") ? tag : mode_tag());
        check(cfg_dout, mword[19], "R2");
        rd = mword[4 + s];
        if (en) begin
            mword = {mword[18:0], din};
        end else begin
            if (w && mword[3:2] == 2'b01) mword[4 + s] = d;
            if (w && mword[3:2] == 2'b10) mword[19:4] = {mword[18:4], d};
            if (r)      mq = mword[0];
            else if (c) mq = rd;
        end
    endtask

    // R10: every load runs with the user controls asserted
    task automatic load(input logic [15:0] tbl, input logic [1:0] md,
                        input logic osel, input logic srv);
        logic [19:0] w;
        w = {tbl, md, osel, srv};
        for (int i = 19; i >= 0; i--)
            cyc(1'b1, w[i], 4'($urandom_range(15)), 1'b1, 1'b1, 1'b1,
                1'($urandom_range(1)), "R10");
    endtask

    task automatic idle(input logic [3:0] s, input string tag);
        cyc(1'b0, 1'b0, s, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(cell_out, 1'b0, "R1");
        check(cfg_dout, 1'b0, "R1");

        // R3 and R4: logic mode, every row
        load(16'hA5C3, 2'b00, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) idle(4'(i), "R3");

        // R11: writes in logic mode do nothing
        for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, 4'(i), 1'b0, 1'b0, 1'b1, ~mword[4+i], "R11");
        for (int i = 0; i < 16; i++) idle(4'(i), "R11");

        // R11: reserved mode reads like logic and ignores writes
        load(16'h3C96, 2'b11, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, 4'(i), 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        for (int i = 0; i < 16; i++) idle(4'(i), "R11");

        // R5: memory writes and asynchronous read-back
        load(16'h0000, 2'b01, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, 4'(i), 1'b0, 1'b0, 1'b1, 1'(i % 3 == 0), "R5");
        for (int i = 15; i >= 0; i--) idle(4'(i), "R5");

        // R6: fill the shift register and sweep all taps
        load(16'hFFFF, 2'b10, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, 4'd15, 1'b0, 1'b0, 1'b1, 1'((16'h6B1D >> i) & 1), "R6");
        for (int i = 0; i < 16; i++) idle(4'(i), "R6");

        // R7, R8, R9: registered output, set value 1
        load(16'h8001, 2'b00, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        idle(4'd0, "R8");
        cyc(1'b0, 1'b0, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        idle(4'd15, "R7");
        idle(4'd15, "R9");
        cyc(1'b0, 1'b0, 4'd15, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        idle(4'd2, "R7");
        load(16'h8001, 2'b00, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 4'd15, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        idle(4'd15, "R8");

        // Random configurations and mixed traffic
        for (int k = 0; k < 12; k++) begin
            load(16'($urandom), 2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)));
            for (int j = 0; j < 150; j++)
                cyc(1'($urandom_range(11) == 0), 1'($urandom_range(1)), 4'($urandom_range(15)),
                    1'($urandom_range(1)), 1'($urandom_range(5) == 0), 1'($urandom_range(1)),
                    1'($urandom_range(1)), "");
        end

        // R1: reset mid-run clears the cell again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mword = '0; mq = 1'b0;
        #1;
        check(cell_out, 1'b0, "R1");
        check(cfg_dout, 1'b0, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule